// File: doc/BRIEF.md
# Dual-Port Tournament Direction Predictor with Target Buffer

This block sits in the fetch stage and answers two branch queries per cycle. For each query address it returns a taken/not-taken guess and, when available, a predicted target.

Direction comes from a contest between two tables of 2-bit saturating counters:
- a bimodal table addressed by the query address alone;
- a gshare table addressed by the query address folded with a global outcome history.

A third table of 2-bit counters, addressed like the bimodal table, decides which of the two is trusted for that address. All three direction tables and the history learn only from branches that retire, through one retire-update port.

Targets come from a small direct-mapped target buffer that learns from resolved branches at the execute stage, through a separate update port. A taken resolution installs or refreshes an entry. A not-taken resolution of the resident branch drops it.

Lookups are combinational reads of registered state, so an update becomes visible on the cycle after it is presented.

Top module: `bp_tournament`

## Requirements
- R1: After a synchronous active-high reset, every direction and chooser counter holds 1 and every target-buffer entry is invalid. Every lookup then predicts not-taken with no target hit.
- R2: Each counter is 2 bits (0 strong not-taken, 1 weak not-taken, 2 weak taken, 3 strong taken), predicts taken when its value is 2 or 3, and saturates at 0 and 3. A retired taken branch moves the counter up and a retired not-taken branch moves it down. The bimodal counter is addressed by address bits [9:2].
- R3: The history register holds the last 8 retired outcomes. On each retire it shifts left and places the new outcome (1 = taken) at bit 0. The gshare counter is addressed by address bits [9:2] XOR the history.
- R4: The chooser counter, addressed by address bits [9:2], selects the bimodal prediction when its value is 0 or 1 and the gshare prediction when its value is 2 or 3.
- R5: On retire, the chooser moves up by one (saturating) when gshare was right and bimodal wrong, and moves down by one (saturating) when bimodal was right and gshare wrong. Otherwise it holds. Correctness is judged on the counter values present at the retire cycle.
- R6: Direction counters, chooser and history change only in cycles with a retire update. Execute-port updates never affect them.
- R7: The target buffer has 32 direct-mapped entries addressed by address bits [6:2], each with a tag (bits [31:7]), a valid bit and a target. A taken execute update writes tag and target and sets valid, replacing whatever the entry held.
- R8: A not-taken execute update whose tag matches the entry clears its valid bit. A not-taken update with a different tag leaves the entry unchanged.
- R9: Each of the two lookup ports reports a hit, with the stored target, only when the entry is valid and its tag matches. Updates presented in a cycle are seen by lookups from the next cycle on.
- R10: Address bits [1:0] have no effect on any lookup or update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc0 | input | 32 | Query address, port 0 |
| lk_pc1 | input | 32 | Query address, port 1 |
| lk_taken0 | output | 1 | Direction guess, port 0 |
| lk_taken1 | output | 1 | Direction guess, port 1 |
| lk_hit0 | output | 1 | Target buffer hit, port 0 |
| lk_hit1 | output | 1 | Target buffer hit, port 1 |
| lk_tgt0 | output | 32 | Predicted target, port 0 |
| lk_tgt1 | output | 32 | Predicted target, port 1 |
| ret_valid | input | 1 | A branch retires this cycle |
| ret_pc | input | 32 | Address of the retiring branch |
| ret_taken | input | 1 | Outcome of the retiring branch |
| ex_valid | input | 1 | A branch resolves at execute this cycle |
| ex_pc | input | 32 | Address of the resolving branch |
| ex_taken | input | 1 | Resolved direction |
| ex_target | input | 32 | Resolved target |

## Verification
The assertions assume that the update inputs are held low during reset and are meaningful whenever their valid strobe is high. They also assume that retire updates arrive in program order, so the history matches the retire stream.

The bench drives idle values throughout reset. It then presents at most one retire and one execute update per cycle, drawn from a generator that mixes a few hot branches (with history-correlated outcomes, which push the chooser towards gshare) and sparse random addresses whose low bits and tags vary. That mix produces target conflicts, mismatched not-taken clears and lookups that land on the entry being written.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_INIT = 2'd1;
    localparam int   N_RD     = 3;   // two lookups plus the retire read

    typedef enum logic [1:0] {
        RD_LK0 = 2'd0,
        RD_LK1 = 2'd1,
        RD_RET = 2'd2
    } rd_port_e;

    typedef struct packed {
        logic bim_ok;
        logic gsh_ok;
    } verdict_t;

    function automatic ctr_t ctr_next(ctr_t c, logic up);
        if (up) return (c == 2'd3) ? c : ctr_t'(c + 2'd1);
        return (c == 2'd0) ? c : ctr_t'(c - 2'd1);
    endfunction

    function automatic logic ctr_taken(ctr_t c);
        return c[1];
    endfunction

    function automatic logic tourney_pick(ctr_t sel, ctr_t bim, ctr_t gsh);
        return sel[1] ? ctr_taken(gsh) : ctr_taken(bim);
    endfunction

endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int NRD   = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NRD-1:0][IDX_W-1:0] rd_idx,
    output ctr_t [NRD-1:0]            rd_val,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic                      wr_up
);
    localparam int ENTRIES = 1 << IDX_W;

    ctr_t tbl [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= CTR_INIT;
        end else if (wr_en) begin
            tbl[wr_idx] <= ctr_next(tbl[wr_idx], wr_up);
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_val[g] = tbl[rd_idx[g]];
    end

    AST_CTR_TOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_up && tbl[wr_idx] == 2'd3) |=> tbl[$past(wr_idx)] == 2'd3); // R2
    AST_CTR_BOTTOM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_up && tbl[wr_idx] == 2'd0) |=> tbl[$past(wr_idx)] == 2'd0); // R2
    AST_CTR_RISE_ONE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_up && tbl[wr_idx] != 2'd3)
        |=> tbl[$past(wr_idx)] == ctr_t'($past(tbl[wr_idx]) + 2'd1)); // R2
    AST_CTR_QUIET: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(tbl[0])); // R6

endmodule

// File: rtl/bp_ghist.sv
module bp_ghist #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist
);
    always_ff @(posedge clk) begin
        if (rst)           hist <= '0;
        else if (shift_en) hist <= {hist[HIST_W-2:0], bit_in};
    end

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (hist[0] == $past(bit_in))
                  && (hist[HIST_W-1:1] == $past(hist[HIST_W-2:0]))); // R3
    AST_HIST_STABLE: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(hist)); // R6

endmodule

// File: rtl/bp_btb.sv
module bp_btb #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 5,
    parameter int NRD   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NRD-1:0][PC_W-1:0] rd_pc,
    output logic [NRD-1:0]           rd_hit,
    output logic [NRD-1:0][PC_W-1:0] rd_tgt,
    input  logic                     wr_en,
    input  logic [PC_W-1:0]          wr_pc,
    input  logic                     wr_taken,
    input  logic [PC_W-1:0]          wr_tgt
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_LSB = 2 + IDX_W;
    localparam int TAG_W   = PC_W - TAG_LSB;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [PC_W-1:0]  tgt;
    } slot_t;

    slot_t slots [ENTRIES];

    logic [IDX_W-1:0] w_idx;
    logic [TAG_W-1:0] w_tag;
    assign w_idx = wr_pc[2 +: IDX_W];
    assign w_tag = wr_pc[PC_W-1:TAG_LSB];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) slots[i] <= '0;
        end else if (wr_en) begin
            if (wr_taken)
                slots[w_idx] <= '{vld: 1'b1, tag: w_tag, tgt: wr_tgt};
            else if (slots[w_idx].tag == w_tag)
                slots[w_idx].vld <= 1'b0;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        slot_t s;
        assign s         = slots[rd_pc[g][2 +: IDX_W]];
        assign rd_hit[g] = s.vld && (s.tag == rd_pc[g][PC_W-1:TAG_LSB]);
        assign rd_tgt[g] = s.tgt;
    end

    AST_BTB_FILL: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken) |=> slots[$past(w_idx)].vld
                             && slots[$past(w_idx)].tag == $past(w_tag)
                             && slots[$past(w_idx)].tgt == $past(wr_tgt)); // R7
    AST_BTB_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && slots[w_idx].tag == w_tag)
        |=> !slots[$past(w_idx)].vld); // R8
    AST_BTB_SPARE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && slots[w_idx].tag != w_tag)
        |=> slots[$past(w_idx)] == $past(slots[w_idx])); // R8

endmodule

// File: rtl/bp_tournament.sv
module bp_tournament
    import bp_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int DIR_IDX_W = 8,
    parameter int BTB_IDX_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lk_pc0,
    input  logic [PC_W-1:0] lk_pc1,
    output logic            lk_taken0,
    output logic            lk_taken1,
    output logic            lk_hit0,
    output logic            lk_hit1,
    output logic [PC_W-1:0] lk_tgt0,
    output logic [PC_W-1:0] lk_tgt1,
    input  logic            ret_valid,
    input  logic [PC_W-1:0] ret_pc,
    input  logic            ret_taken,
    input  logic            ex_valid,
    input  logic [PC_W-1:0] ex_pc,
    input  logic            ex_taken,
    input  logic [PC_W-1:0] ex_target
);
    localparam int HIST_W = DIR_IDX_W;

    logic [N_RD-1:0][PC_W-1:0]      rd_pc;
    logic [N_RD-1:0][DIR_IDX_W-1:0] pc_idx, gsh_idx;
    ctr_t [N_RD-1:0]                bim_v, gsh_v, cho_v;
    logic [N_RD-1:0]                dir_guess;
    logic [HIST_W-1:0]              hist;
    verdict_t                       vrd;
    logic                           cho_wr;

    assign rd_pc[RD_LK0] = lk_pc0;
    assign rd_pc[RD_LK1] = lk_pc1;
    assign rd_pc[RD_RET] = ret_pc;

    for (genvar p = 0; p < N_RD; p++) begin : g_port
        assign pc_idx[p]    = rd_pc[p][2 +: DIR_IDX_W];
        assign gsh_idx[p]   = pc_idx[p] ^ hist;
        assign dir_guess[p] = tourney_pick(cho_v[p], bim_v[p], gsh_v[p]);
    end

    bp_ghist #(.HIST_W(HIST_W)) u_hist (
        .clk(clk), .rst(rst), .shift_en(ret_valid), .bit_in(ret_taken), .hist(hist)
    );

    bp_ctr_table #(.IDX_W(DIR_IDX_W), .NRD(N_RD)) u_bim (
        .clk(clk), .rst(rst), .rd_idx(pc_idx), .rd_val(bim_v),
        .wr_en(ret_valid), .wr_idx(pc_idx[RD_RET]), .wr_up(ret_taken)
    );

    bp_ctr_table #(.IDX_W(DIR_IDX_W), .NRD(N_RD)) u_gsh (
        .clk(clk), .rst(rst), .rd_idx(gsh_idx), .rd_val(gsh_v),
        .wr_en(ret_valid), .wr_idx(gsh_idx[RD_RET]), .wr_up(ret_taken)
    );

    // chooser trains only when exactly one component was right
    assign vrd.bim_ok = ctr_taken(bim_v[RD_RET]) == ret_taken;
    assign vrd.gsh_ok = ctr_taken(gsh_v[RD_RET]) == ret_taken;
    assign cho_wr     = ret_valid && (vrd.bim_ok != vrd.gsh_ok);

    bp_ctr_table #(.IDX_W(DIR_IDX_W), .NRD(N_RD)) u_cho (
        .clk(clk), .rst(rst), .rd_idx(pc_idx), .rd_val(cho_v),
        .wr_en(cho_wr), .wr_idx(pc_idx[RD_RET]), .wr_up(vrd.gsh_ok)
    );

    logic [1:0][PC_W-1:0] btb_pc, btb_tgt;
    logic [1:0]           btb_hit;
    assign btb_pc[0] = lk_pc0;
    assign btb_pc[1] = lk_pc1;

    bp_btb #(.PC_W(PC_W), .IDX_W(BTB_IDX_W), .NRD(2)) u_btb (
        .clk(clk), .rst(rst), .rd_pc(btb_pc), .rd_hit(btb_hit), .rd_tgt(btb_tgt),
        .wr_en(ex_valid), .wr_pc(ex_pc), .wr_taken(ex_taken), .wr_tgt(ex_target)
    );

    assign lk_taken0 = dir_guess[RD_LK0];
    assign lk_taken1 = dir_guess[RD_LK1];
    assign lk_hit0   = btb_hit[0];
    assign lk_hit1   = btb_hit[1];
    assign lk_tgt0   = btb_tgt[0];
    assign lk_tgt1   = btb_tgt[1];

    AST_CHO_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && vrd.bim_ok == vrd.gsh_ok && pc_idx[RD_RET] == pc_idx[RD_LK0])
        |=> $stable(cho_v[RD_LK0]) || !$stable(lk_pc0)); // R5
    AST_DIR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !ret_valid |=> $stable(hist)); // R6
    AST_LOWBITS_SAME: assert property (@(posedge clk) disable iff (rst)
        (lk_pc0[PC_W-1:2] == lk_pc1[PC_W-1:2])
        |-> (lk_taken0 == lk_taken1) && (lk_hit0 == lk_hit1)); // R10

endmodule

// File: tb/tb_bp_tournament.sv
module tb_bp_tournament;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 6000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lk_pc0 = '0, lk_pc1 = '0, ret_pc = '0, ex_pc = '0, ex_target = '0;
    logic        ret_valid = 1'b0, ret_taken = 1'b0, ex_valid = 1'b0, ex_taken = 1'b0;
    logic        lk_taken0, lk_taken1, lk_hit0, lk_hit1;
    logic [31:0] lk_tgt0, lk_tgt1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bp_tournament dut (
        .clk(clk), .rst(rst),
        .lk_pc0(lk_pc0), .lk_pc1(lk_pc1),
        .lk_taken0(lk_taken0), .lk_taken1(lk_taken1),
        .lk_hit0(lk_hit0), .lk_hit1(lk_hit1),
        .lk_tgt0(lk_tgt0), .lk_tgt1(lk_tgt1),
        .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_taken(ret_taken),
        .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_taken(ex_taken), .ex_target(ex_target)
    );

    int errors = 0;
    int checks = 0;

    // reference state
    logic [1:0]  m_bim [256];
    logic [1:0]  m_gsh [256];
    logic [1:0]  m_cho [256];
    logic [7:0]  m_hist;
    logic        m_bv  [32];
    logic [24:0] m_btag[32];
    logic [31:0] m_btgt[32];
    logic [31:0] seed = 32'h1234_5678;

    function automatic logic [1:0] step(logic [1:0] c, logic up);
        if (up) return (c == 2'd3) ? 2'd3 : c + 2'd1;
        return (c == 2'd0) ? 2'd0 : c - 2'd1;
    endfunction

    function automatic logic exp_dir(logic [31:0] pc);
        logic [7:0] i;
        i = pc[9:2];
        if (m_cho[i] >= 2'd2) return m_gsh[i ^ m_hist] >= 2'd2;
        return m_bim[i] >= 2'd2;
    endfunction

    function automatic logic exp_hit(logic [31:0] pc);
        return m_bv[pc[6:2]] && m_btag[pc[6:2]] == pc[31:7];
    endfunction

    function automatic logic [31:0] nxt(logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 17);
        return x ^ (x << 5);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_ports();
        chk("R2 R3 R4 R5 R10 direction port0", 32'(lk_taken0), 32'(exp_dir(lk_pc0)));
        chk("R2 R3 R4 R5 R10 direction port1", 32'(lk_taken1), 32'(exp_dir(lk_pc1)));
        chk("R7 R8 R9 R10 hit port0", 32'(lk_hit0), 32'(exp_hit(lk_pc0)));
        chk("R7 R8 R9 R10 hit port1", 32'(lk_hit1), 32'(exp_hit(lk_pc1)));
        if (exp_hit(lk_pc0)) chk("R7 R9 target port0", lk_tgt0, m_btgt[lk_pc0[6:2]]);
        if (exp_hit(lk_pc1)) chk("R7 R9 target port1", lk_tgt1, m_btgt[lk_pc1[6:2]]);
    endtask

    task automatic model_commit();
        logic [7:0] i;
        logic [7:0] gi;
        logic       bok, gok;
        if (ret_valid) begin
            i   = ret_pc[9:2];
            gi  = i ^ m_hist;
            bok = (m_bim[i] >= 2'd2) == ret_taken;
            gok = (m_gsh[gi] >= 2'd2) == ret_taken;
            if (gok && !bok) m_cho[i] = step(m_cho[i], 1'b1);
            if (bok && !gok) m_cho[i] = step(m_cho[i], 1'b0);
            m_bim[i] = step(m_bim[i], ret_taken);
            m_gsh[gi] = step(m_gsh[gi], ret_taken);
            m_hist = {m_hist[6:0], ret_taken};
        end
        if (ex_valid) begin
            if (ex_taken) begin
                m_bv[ex_pc[6:2]]   = 1'b1;
                m_btag[ex_pc[6:2]] = ex_pc[31:7];
                m_btgt[ex_pc[6:2]] = ex_target;
            end else if (m_btag[ex_pc[6:2]] == ex_pc[31:7]) begin
                m_bv[ex_pc[6:2]] = 1'b0;
            end
        end
    endtask

    function automatic logic [31:0] pick_pc(logic [31:0] r);
        logic [31:0] hot [4];
        hot[0] = 32'h0000_0040; hot[1] = 32'h0010_0044;
        hot[2] = 32'h0000_0388; hot[3] = 32'h0000_0140;
        if (r[24:23] != 2'd0) return hot[r[26:25]] | 32'(r[1:0]);
        return (r & 32'h0000_0FFF) | (r[20] ? 32'h0010_0000 : 32'h0);
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) begin
            m_bim[i] = 2'd1; m_gsh[i] = 2'd1; m_cho[i] = 2'd1;
        end
        for (int i = 0; i < 32; i++) begin
            m_bv[i] = 1'b0; m_btag[i] = '0; m_btgt[i] = '0;
        end
        m_hist = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state over every direction index, both ports, odd low bits
        for (int i = 0; i < 256; i++) begin
            lk_pc0 = 32'(i) << 2;
            lk_pc1 = (32'(i) << 2) | 32'h0010_0003;
            #2;
            chk("R1 reset direction port0", 32'(lk_taken0), 32'd0);
            chk("R1 reset direction port1", 32'(lk_taken1), 32'd0);
            chk("R1 reset hit port0", 32'(lk_hit0), 32'd0);
            chk("R1 reset hit port1", 32'(lk_hit1), 32'd0);
            @(negedge clk);
        end

        // R6 R7 R8: random mixed updates compared against the reference
        for (int n = 0; n < N_RANDOM; n++) begin
            logic [31:0] r;
            seed = nxt(seed); r = seed;
            ret_valid = r[0];
            ret_pc    = pick_pc(nxt(r ^ 32'h5a5a_0001));
            ret_taken = (r[24:23] != 2'd0) ? ~m_hist[0] : r[3];
            seed = nxt(seed);
            ex_valid  = seed[1];
            ex_pc     = pick_pc(seed);
            ex_taken  = seed[29];
            ex_target = nxt(seed ^ 32'h0F0F_1357);
            seed = nxt(seed);
            // bias lookups onto the entry being written on some cycles
            lk_pc0 = seed[31] ? (ex_pc ^ 32'(seed[1:0])) : pick_pc(seed);
            seed = nxt(seed);
            lk_pc1 = seed[31] ? ret_pc : pick_pc(seed);
            #2;
            check_ports();
            @(posedge clk);
            model_commit();
            @(negedge clk);
        end
        ret_valid = 1'b0; ex_valid = 1'b0;
        #2;
        check_ports();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule